// File: doc/BRIEF.md
# I2C Target Address Matcher

This block sits behind the bit-level shifter of an I2C target and decides, byte by byte, whether the target takes part in the current transfer. It looks at each address byte it receives. It compares that byte with a set of programmed 7-bit addresses, or with a single 10-bit address when that mode is selected. It also recognises the general call. When the hardware general call option is on, it checks the byte that follows a general call against a stored alternate address. For every byte that needs an answer, it produces the acknowledge decision. It also raises receive and transmit requests, keeps a sticky record of general calls, and gates four interrupt sources through their enables.

The shifter supplies the assembled byte with a one-cycle `byte_done` strobe at the rising SCL edge of the eighth bit. For an address byte, that eighth bit is the direction bit. The shifter also supplies a one-cycle `ack_slot_end` strobe when the acknowledge clock has finished, plus one-cycle start, repeated-start and stop detect strobes. Control inputs are treated as stable register bits. `nack_next_set` and `gc_clr` are write pulses. All outputs are registered and respond one clock after the strobe that caused them.

Top module: `i2c_tgt_addr_match`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every output is 0. This includes `nack_next`, `gc_status`, `gc_id` and `irq`.
- R2: With `cfg_ten_bit`=0, an address byte whose bits [7:1] equal any programmed entry `tgt_addr[7i+6:7i]` is acknowledged (`ack_vld`=1, `ack_ok`=1) one cycle after `byte_done`. `addressed` becomes 1 and `rd_dir` takes bit 0 (1 = read). A byte that matches no entry gets `ack_vld`=1 and `ack_ok`=0. The rest of that transfer then produces no `ack_vld` and no `rx_req`.
- R3: With `cfg_ten_bit`=1, the 7-bit entries are ignored. A first byte of 11110, `tgt_addr10[9:8]`, 0 is acknowledged without setting `addressed`. A second byte equal to `tgt_addr10[7:0]` is acknowledged and sets `addressed` with `rd_dir`=0. A different second byte is not acknowledged.
- R4: After a completed 10-bit write match, a repeated start followed by 11110, `tgt_addr10[9:8]`, 1 is acknowledged as a read. After a stop, the same read byte is not acknowledged.
- R5: Address byte 0x00 is acknowledged only when `cfg_gc_en`=1. It sets `gc_status`=1 and `gc_id`=0. Byte 0x01 is never acknowledged as a general call.
- R6: With `cfg_gc_en` and `cfg_hgc_en` both set, the byte after an acknowledged general call is acknowledged, and `gc_id` becomes 1 when that byte equals `alt_addr`. It stays 0 otherwise.
- R7: `gc_status` and `gc_id` keep their value through stops and starts. Only a `gc_clr` pulse or reset clears them. When a clear and a general call arrive in the same cycle, the clear wins.
- R8: A `nack_next_set` pulse sets `nack_next`. The next address byte that would have been acknowledged is answered `ack_ok`=0, leaves `addressed` at 0, and clears `nack_next`. Address bytes that match nothing leave it set.
- R9: In a write transfer in which the target is addressed, each data byte is acknowledged, with an `rx_req` pulse one cycle after `byte_done`.
- R10: In a read transfer with `cfg_early_tx`=0, `tx_req` pulses one cycle after each `ack_slot_end`. With `cfg_early_tx`=1, the request for the first byte pulses one cycle after the address `byte_done` instead, and the address `ack_slot_end` raises none.
- R11: `irq[0]` (repeated start), `irq[1]` (stop), `irq[2]` (receive request) and `irq[3]` (transmit request) each pulse one cycle after their event when the matching `irq_en` bit is 1. They never pulse when it is 0.
- R12: A stop clears `addressed` and `rd_dir` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Byte assembled by the shifter |
| byte_done | input | 1 | Byte complete, at the SCL rise of bit 8 |
| ack_slot_end | input | 1 | Acknowledge clock finished |
| start_det | input | 1 | Start condition seen |
| rstart_det | input | 1 | Repeated start seen |
| stop_det | input | 1 | Stop condition seen |
| cfg_ten_bit | input | 1 | Select 10-bit addressing |
| cfg_gc_en | input | 1 | Answer general call |
| cfg_hgc_en | input | 1 | Check byte after general call against alternate address |
| cfg_early_tx | input | 1 | Raise first transmit request at the direction bit |
| nack_next_set | input | 1 | Pulse: refuse the next addressed transfer |
| gc_clr | input | 1 | Pulse: clear general call status and ID |
| irq_en | input | 4 | Interrupt enables {tx, rx, stop, rstart} |
| tgt_addr | input | NUM_ADDR*7 | Packed 7-bit target addresses |
| tgt_addr10 | input | 10 | 10-bit target address |
| alt_addr | input | 8 | Alternate address for hardware general call |
| ack_vld | output | 1 | An acknowledge decision is presented |
| ack_ok | output | 1 | Decision: 1 = acknowledge |
| addressed | output | 1 | Target is taking part in the transfer |
| rd_dir | output | 1 | Current transfer is a read |
| rx_req | output | 1 | Received data byte ready |
| tx_req | output | 1 | Transmit byte needed |
| gc_status | output | 1 | Sticky general call seen |
| gc_id | output | 1 | Last general call was a hardware one |
| nack_next | output | 1 | Refuse-next pending |
| irq | output | 4 | Interrupt pulses {tx, rx, stop, rstart} |

## Verification
The hardest case to reach from the ports is the 10-bit read. It needs three steps in order: a two-byte write match, a repeated start, and then a read byte with the 10-bit prefix. The bench builds exactly that sequence. It then repeats the read byte after a stop and expects a refusal. A second hard case is the clear winning over a general call in the same cycle. The bench reaches it by raising `gc_clr` in the very cycle that carries the 0x00 address strobe. The refuse-next control is also driven through a non-matching transfer first, to show that only an addressed transfer consumes it.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR2,
    ST_GCDATA,
    ST_DATA,
    ST_SKIP
  } am_state_e;

  localparam logic [4:0] TEN_PREFIX = 5'b11110;
  localparam logic [7:0] GC_BYTE    = 8'h00;
  localparam int unsigned IRQ_N     = 4;
endpackage

// File: rtl/am_addr_cmp.sv
module am_addr_cmp #(
  parameter int unsigned NUM_ADDR = 4,
  parameter int unsigned AW       = 7
) (
  input  logic [7:0]             rx_byte,
  input  logic [NUM_ADDR*AW-1:0] addr_tbl,
  output logic                   hit
);
  logic [NUM_ADDR-1:0] eq;

  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_cmp
    assign eq[i] = (rx_byte[7:8-AW] == addr_tbl[i*AW +: AW]);
  end

  assign hit = |eq;
endmodule

// File: rtl/am_ten_cmp.sv
module am_ten_cmp
  import i2c_am_pkg::*;
#(
  parameter int unsigned AW10 = 10
) (
  input  logic [7:0]      rx_byte,
  input  logic [AW10-1:0] addr10,
  output logic            hi_wr,
  output logic            hi_rd,
  output logic            lo_eq
);
  logic hi_match;

  assign hi_match = (rx_byte[7:3] == TEN_PREFIX) &&
                    (rx_byte[2:1] == addr10[AW10-1:AW10-2]);
  assign hi_wr = hi_match && !rx_byte[0];
  assign hi_rd = hi_match && rx_byte[0];
  assign lo_eq = (rx_byte == addr10[7:0]);
endmodule

// File: rtl/am_gc_track.sv
module am_gc_track (
  input  logic clk,
  input  logic rst,
  input  logic gc_set,
  input  logic hgc_set,
  input  logic clr,
  output logic status,
  output logic id
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      status <= 1'b0;
      id     <= 1'b0;
    end else if (gc_set) begin
      status <= 1'b1;
      id     <= 1'b0;
    end else if (hgc_set) begin
      id     <= 1'b1;
    end
  end
endmodule

// File: rtl/am_irq.sv
module am_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] en,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_irq
    always_ff @(posedge clk) begin
      if (rst) irq[i] <= 1'b0;
      else     irq[i] <= ev[i] && en[i];
    end
  end
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
  import i2c_am_pkg::*;
#(
  parameter int unsigned NUM_ADDR = 4,
  parameter int unsigned AW7      = 7,
  parameter int unsigned AW10     = 10,
  localparam int unsigned TBL_W   = NUM_ADDR * AW7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rx_byte,
  input  logic             byte_done,
  input  logic             ack_slot_end,
  input  logic             start_det,
  input  logic             rstart_det,
  input  logic             stop_det,
  input  logic             cfg_ten_bit,
  input  logic             cfg_gc_en,
  input  logic             cfg_hgc_en,
  input  logic             cfg_early_tx,
  input  logic             nack_next_set,
  input  logic             gc_clr,
  input  logic [3:0]       irq_en,
  input  logic [TBL_W-1:0] tgt_addr,
  input  logic [AW10-1:0]  tgt_addr10,
  input  logic [7:0]       alt_addr,
  output logic             ack_vld,
  output logic             ack_ok,
  output logic             addressed,
  output logic             rd_dir,
  output logic             rx_req,
  output logic             tx_req,
  output logic             gc_status,
  output logic             gc_id,
  output logic             nack_next,
  output logic [3:0]       irq
);
  am_state_e state, nx_state;
  logic ten_rd_ok, skip_tx;
  logic nx_addr, nx_rd, nx_tenrd, nx_skip;
  logic d_vld, d_ack, d_rx, d_tx, consume, gc_set, hgc_set;
  logic hit7, hi_wr, hi_rd, lo_eq;
  logic is_gc, m7, mten_w, mten_r, hit_any;

  am_addr_cmp #(.NUM_ADDR(NUM_ADDR), .AW(AW7)) u_cmp7 (
    .rx_byte(rx_byte), .addr_tbl(tgt_addr), .hit(hit7)
  );

  am_ten_cmp #(.AW10(AW10)) u_cmp10 (
    .rx_byte(rx_byte), .addr10(tgt_addr10),
    .hi_wr(hi_wr), .hi_rd(hi_rd), .lo_eq(lo_eq)
  );

  assign is_gc   = cfg_gc_en && (rx_byte == GC_BYTE);
  assign m7      = !cfg_ten_bit && hit7;
  assign mten_w  = cfg_ten_bit && hi_wr;
  assign mten_r  = cfg_ten_bit && hi_rd && ten_rd_ok;
  assign hit_any = is_gc || m7 || mten_w || mten_r;

  always_comb begin
    nx_state = state;
    nx_addr  = addressed;
    nx_rd    = rd_dir;
    nx_tenrd = ten_rd_ok;
    nx_skip  = skip_tx;
    d_vld    = 1'b0;
    d_ack    = 1'b0;
    d_rx     = 1'b0;
    d_tx     = 1'b0;
    consume  = 1'b0;
    gc_set   = 1'b0;
    hgc_set  = 1'b0;
    if (stop_det) begin
      nx_state = ST_IDLE;
      nx_addr  = 1'b0;
      nx_rd    = 1'b0;
      nx_tenrd = 1'b0;
      nx_skip  = 1'b0;
    end else if (start_det || rstart_det) begin
      nx_state = ST_ADDR;
      nx_addr  = 1'b0;
      nx_rd    = 1'b0;
      nx_skip  = 1'b0;
      if (start_det) nx_tenrd = 1'b0;
    end else if (ack_slot_end) begin
      if (addressed && rd_dir) begin
        if (skip_tx) nx_skip = 1'b0;
        else         d_tx    = 1'b1;
      end
    end else if (byte_done) begin
      unique case (state)
        ST_ADDR: begin
          d_vld = 1'b1;
          if (!hit_any) begin
            nx_state = ST_SKIP;
          end else if (nack_next) begin
            consume  = 1'b1;
            nx_state = ST_SKIP;
          end else begin
            d_ack = 1'b1;
            if (is_gc) begin
              gc_set   = 1'b1;
              nx_addr  = 1'b1;
              nx_rd    = 1'b0;
              nx_state = cfg_hgc_en ? ST_GCDATA : ST_DATA;
            end else if (mten_w) begin
              nx_state = ST_ADDR2;
            end else begin
              nx_addr  = 1'b1;
              nx_rd    = rx_byte[0];
              nx_state = ST_DATA;
              if (rx_byte[0] && cfg_early_tx) begin
                d_tx    = 1'b1;
                nx_skip = 1'b1;
              end
            end
          end
        end
        ST_ADDR2: begin
          d_vld = 1'b1;
          if (lo_eq) begin
            d_ack    = 1'b1;
            nx_addr  = 1'b1;
            nx_rd    = 1'b0;
            nx_tenrd = 1'b1;
            nx_state = ST_DATA;
          end else begin
            nx_state = ST_SKIP;
          end
        end
        ST_GCDATA: begin
          d_vld    = 1'b1;
          d_ack    = 1'b1;
          d_rx     = 1'b1;
          hgc_set  = cfg_hgc_en && (rx_byte == alt_addr);
          nx_state = ST_DATA;
        end
        ST_DATA: begin
          if (!rd_dir) begin
            d_vld = 1'b1;
            d_ack = 1'b1;
            d_rx  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      addressed <= 1'b0;
      rd_dir    <= 1'b0;
      ten_rd_ok <= 1'b0;
      skip_tx   <= 1'b0;
      nack_next <= 1'b0;
      ack_vld   <= 1'b0;
      ack_ok    <= 1'b0;
      rx_req    <= 1'b0;
      tx_req    <= 1'b0;
    end else begin
      state     <= nx_state;
      addressed <= nx_addr;
      rd_dir    <= nx_rd;
      ten_rd_ok <= nx_tenrd;
      skip_tx   <= nx_skip;
      nack_next <= (nack_next && !consume) || nack_next_set;
      ack_vld   <= d_vld;
      ack_ok    <= d_ack;
      rx_req    <= d_rx;
      tx_req    <= d_tx;
    end
  end

  am_gc_track u_gc (
    .clk(clk), .rst(rst), .gc_set(gc_set), .hgc_set(hgc_set),
    .clr(gc_clr), .status(gc_status), .id(gc_id)
  );

  am_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst(rst),
    .ev({d_tx, d_rx, stop_det, rstart_det}),
    .en(irq_en), .irq(irq)
  );
endmodule

// File: rtl/i2c_tgt_addr_match_chk.sv
module i2c_tgt_addr_match_chk (
  input logic       clk,
  input logic       rst,
  input logic       stop_det,
  input logic       gc_clr,
  input logic [3:0] irq_en,
  input logic       ack_vld,
  input logic       ack_ok,
  input logic       addressed,
  input logic       rx_req,
  input logic       gc_status,
  input logic       gc_id,
  input logic       nack_next,
  input logic [3:0] irq
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!addressed && !ack_vld && !gc_status && !nack_next && irq == 4'h0));

  assert_gcid_with_status_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(gc_id) |-> gc_status);

  assert_gc_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(gc_status) |-> $past(gc_clr));

  assert_nack_consumed_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(nack_next) |-> (ack_vld && !ack_ok));

  assert_rx_acked_R9: assert property (@(posedge clk) disable iff (rst)
    rx_req |-> (ack_vld && ack_ok));

  assert_stop_irq_R11: assert property (@(posedge clk) disable iff (rst)
    irq[1] |-> ($past(stop_det) && $past(irq_en[1])));

  assert_stop_release_R12: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !addressed);
endmodule

bind i2c_tgt_addr_match i2c_tgt_addr_match_chk chk_i (
  .clk(clk), .rst(rst), .stop_det(stop_det), .gc_clr(gc_clr),
  .irq_en(irq_en), .ack_vld(ack_vld), .ack_ok(ack_ok),
  .addressed(addressed), .rx_req(rx_req), .gc_status(gc_status),
  .gc_id(gc_id), .nack_next(nack_next), .irq(irq)
);

// File: tb/i2c_tgt_addr_match_tb_top.sv
module i2c_tgt_addr_match_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] rx_byte = '0;
  logic byte_done = 0, ack_slot_end = 0, start_det = 0, rstart_det = 0, stop_det = 0;
  logic cfg_ten_bit = 0, cfg_gc_en = 0, cfg_hgc_en = 0, cfg_early_tx = 0;
  logic nack_next_set = 0, gc_clr = 0;
  logic [3:0] irq_en = '0;
  logic [27:0] tgt_addr = {7'h44, 7'h33, 7'h22, 7'h11};
  logic [9:0] tgt_addr10 = 10'h2A5;
  logic [7:0] alt_addr = 8'h35;
  logic ack_vld, ack_ok, addressed, rd_dir, rx_req, tx_req, gc_status, gc_id, nack_next;
  logic [3:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit clr_with_byte = 0;
  bit exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  i2c_tgt_addr_match dut_i (
    .clk(clk), .rst(rst), .rx_byte(rx_byte), .byte_done(byte_done),
    .ack_slot_end(ack_slot_end), .start_det(start_det), .rstart_det(rstart_det),
    .stop_det(stop_det), .cfg_ten_bit(cfg_ten_bit), .cfg_gc_en(cfg_gc_en),
    .cfg_hgc_en(cfg_hgc_en), .cfg_early_tx(cfg_early_tx),
    .nack_next_set(nack_next_set), .gc_clr(gc_clr), .irq_en(irq_en),
    .tgt_addr(tgt_addr), .tgt_addr10(tgt_addr10), .alt_addr(alt_addr),
    .ack_vld(ack_vld), .ack_ok(ack_ok), .addressed(addressed), .rd_dir(rd_dir),
    .rx_req(rx_req), .tx_req(tx_req), .gc_status(gc_status), .gc_id(gc_id),
    .nack_next(nack_next), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Monitor: each presented decision is matched against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst && ack_vld) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected decision: got ack=%0b expected none", ack_ok);
      end else begin
        automatic bit e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (ack_ok !== e) begin
          errors++;
          $display("FAIL %s ack: got %0b expected %0b", t, ack_ok, e);
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] b, input bit exp_vld, input bit exp_ack,
                           input string req);
    if (exp_vld) begin
      exp_q.push_back(exp_ack);
      tag_q.push_back(req);
    end
    @(negedge clk);
    rx_byte = b; byte_done = 1'b1; gc_clr = clr_with_byte;
    @(negedge clk);
    byte_done = 1'b0; gc_clr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_det = 1'b1; @(negedge clk); start_det = 1'b0;
  endtask
  task automatic pulse_rstart();
    @(negedge clk); rstart_det = 1'b1; @(negedge clk); rstart_det = 1'b0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_det = 1'b1; @(negedge clk); stop_det = 1'b0;
  endtask
  task automatic pulse_ackslot();
    @(negedge clk); ack_slot_end = 1'b1; @(negedge clk); ack_slot_end = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {addressed, ack_vld, gc_status, gc_id, nack_next, irq}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {addressed, rd_dir, rx_req, tx_req, nack_next, irq}, 0);

    // R2: 7-bit write match on third entry, data byte
    pulse_start();
    send_byte(8'h66, 1, 1, "R2 write addr");
    chk("R2 addressed", addressed, 1);
    chk("R2 dir write", rd_dir, 0);
    send_byte(8'hAB, 1, 1, "R9 data");
    chk("R9 rx_req", rx_req, 1);
    pulse_stop();
    chk("R12 stop clears", addressed, 0);
    chk("R11 stop irq disabled", irq, 0);

    // R2: mismatch, rest of transfer ignored
    pulse_start();
    send_byte(8'hAA, 1, 0, "R2 miss");
    chk("R2 miss addressed", addressed, 0);
    send_byte(8'h5A, 0, 0, "R2 ignored");
    chk("R2 ignored rx", rx_req, 0);
    pulse_stop();

    // R10 normal read on fourth entry
    pulse_start();
    send_byte(8'h89, 1, 1, "R2 read addr");
    chk("R2 dir read", rd_dir, 1);
    chk("R10 no tx at byte", tx_req, 0);
    pulse_ackslot();
    chk("R10 tx after slot", tx_req, 1);
    pulse_ackslot();
    chk("R10 tx second", tx_req, 1);
    pulse_stop();
    chk("R12 rd cleared", rd_dir, 0);

    // R10 early mode
    cfg_early_tx = 1'b1;
    pulse_start();
    send_byte(8'h23, 1, 1, "R10 early addr");
    chk("R10 early tx", tx_req, 1);
    pulse_ackslot();
    chk("R10 early no dup", tx_req, 0);
    pulse_ackslot();
    chk("R10 early next", tx_req, 1);
    pulse_stop();
    cfg_early_tx = 1'b0;

    // R3 / R4 ten-bit
    cfg_ten_bit = 1'b1;
    pulse_start();
    send_byte(8'h66, 1, 0, "R3 seven ignored");
    pulse_stop();
    pulse_start();
    send_byte(8'hF4, 1, 1, "R3 first");
    chk("R3 not yet addressed", addressed, 0);
    send_byte(8'hA5, 1, 1, "R3 second");
    chk("R3 addressed", addressed, 1);
    pulse_rstart();
    send_byte(8'hF5, 1, 1, "R4 read after rstart");
    chk("R4 addressed", addressed, 1);
    chk("R4 dir", rd_dir, 1);
    pulse_stop();
    pulse_start();
    send_byte(8'hF5, 1, 0, "R4 read after stop");
    chk("R4 not addressed", addressed, 0);
    pulse_stop();
    pulse_start();
    send_byte(8'hF4, 1, 1, "R3 first again");
    send_byte(8'hA6, 1, 0, "R3 wrong low");
    chk("R3 wrong low", addressed, 0);
    pulse_stop();
    cfg_ten_bit = 1'b0;

    // R5 general call
    pulse_start();
    send_byte(8'h00, 1, 0, "R5 gc disabled");
    chk("R5 no status", gc_status, 0);
    pulse_stop();
    cfg_gc_en = 1'b1;
    pulse_start();
    send_byte(8'h00, 1, 1, "R5 gc");
    chk("R5 status", gc_status, 1);
    chk("R5 id", gc_id, 0);
    send_byte(8'h12, 1, 1, "R9 gc data");
    pulse_stop();
    chk("R7 status sticky", gc_status, 1);
    pulse_start();
    send_byte(8'h01, 1, 0, "R5 gc read");
    pulse_stop();

    // R6 hardware general call
    cfg_hgc_en = 1'b1;
    pulse_start();
    send_byte(8'h00, 1, 1, "R6 gc");
    send_byte(8'h35, 1, 1, "R6 alt byte");
    chk("R6 id hw", gc_id, 1);
    pulse_stop();
    chk("R7 id sticky", gc_id, 1);
    @(negedge clk); gc_clr = 1'b1; @(negedge clk); gc_clr = 1'b0;
    chk("R7 cleared", {gc_status, gc_id}, 0);
    pulse_start();
    send_byte(8'h00, 1, 1, "R6 gc2");
    send_byte(8'h37, 1, 1, "R6 other byte");
    chk("R6 id normal", {gc_status, gc_id}, 2'b10);
    pulse_stop();
    pulse_start();
    clr_with_byte = 1'b1;
    send_byte(8'h00, 1, 1, "R7 gc with clear");
    clr_with_byte = 1'b0;
    chk("R7 clear wins", gc_status, 0);
    pulse_stop();
    cfg_hgc_en = 1'b0;
    cfg_gc_en = 1'b0;

    // R8 refuse next
    @(negedge clk); nack_next_set = 1'b1; @(negedge clk); nack_next_set = 1'b0;
    chk("R8 set", nack_next, 1);
    pulse_start();
    send_byte(8'hAA, 1, 0, "R8 miss");
    chk("R8 kept", nack_next, 1);
    pulse_stop();
    pulse_start();
    send_byte(8'h22, 1, 0, "R8 refused");
    chk("R8 not addressed", addressed, 0);
    chk("R8 consumed", nack_next, 0);
    send_byte(8'h77, 0, 0, "R8 data ignored");
    chk("R8 no rx", rx_req, 0);
    pulse_stop();
    pulse_start();
    send_byte(8'h22, 1, 1, "R8 later accepted");
    pulse_stop();

    // R11 interrupts
    irq_en = 4'hF;
    pulse_rstart();
    chk("R11 rstart irq", irq, 4'b0001);
    pulse_stop();
    chk("R11 stop irq", irq, 4'b0010);
    pulse_start();
    send_byte(8'h22, 1, 1, "R11 addr");
    send_byte(8'h44, 1, 1, "R11 data");
    chk("R11 rx irq", irq, 4'b0100);
    pulse_rstart();
    send_byte(8'h23, 1, 1, "R11 read addr");
    pulse_ackslot();
    chk("R11 tx irq", irq, 4'b1000);
    irq_en = 4'h0;
    pulse_stop();
    chk("R11 disabled", irq, 4'b0000);

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule